// File: doc/BRIEF.md
# Status Channel Sync-Loss Monitor

This block sits beside the receive side of a 2-bit status channel. The channel carries per-port flow-control status and a DIP2 check back to a packet transmitter. A front end outside this block decodes every status frame into two flags: whether the DIP2 check failed, and whether the reserved framing code (binary 11) appeared where no framing was due. The monitor keeps two independent runs of consecutive bad frames, one for DIP2 failures and one for unexpected framing. Each run is compared against its own programmable 4-bit limit, and a limit of zero switches that check off. When a run goes past its limit, the monitor declares loss of sync.

The monitor gathers eight event sources into sticky status bits. Four of them are its own (DIP2 error, no-sync, unexpected framing, framing error). The other four are error pulses from neighbouring logic (calendar parity on either bank, oversized burst, data FIFO overflow). An interrupt mask chooses which sticky bits drive the interrupt line. A separate fatal mask chooses which events count as fatal. A fatal event sets the sync-error bit and raises a forced-training request, which keeps the transmit datapath sending training patterns. The request stays up until software takes the interface enable low and then high again.

Frames arrive as single-cycle strobes. The monitor accepts one every cycle, so it exerts no back-pressure and has no ready signal. Software programs the limits and masks through a small write port and clears sticky bits by writing ones. Sticky state is visible on a status output.

Top module: `stat_sync_monitor`

## Requirements
- R1: After reset, every status bit, `irq`, `sync_err` and `force_train` are 0, and both limits and both masks are 0.
- R2: A frame accepted with `frm_dip_bad`=1 sets status bit 4 at the next clock edge.
- R3: A frame accepted with `frm_unexp`=1 sets status bit 6 at the next clock edge.
- R4: With DIP2 limit L (1..15), the (L+1)th consecutive DIP2-bad frame sets status bit 5 (no-sync). An accepted frame with `frm_dip_bad`=0 restarts the run.
- R5: With framing limit L (1..15), the (L+1)th consecutive unexpected-framing frame sets status bit 7 (framing error). An accepted frame with `frm_unexp`=0 restarts the run.
- R6: A limit of 0 disables its check: no run length sets bit 5 or bit 7 respectively.
- R7: `ext_evt[3:0]` pulses set status bits 3:0. The bit order is: bit 0 calendar parity bank 0, bit 1 calendar parity bank 1, bit 2 oversized burst, bit 3 data FIFO overflow.
- R8: `irq` is 1 exactly when some status bit i (0..7) is set and interrupt-mask bit i is set.
- R9: An event whose fatal-mask bit is set sets status bit 8 (`sync_err`) and `force_train` at the next edge. An event whose fatal-mask bit is clear affects neither.
- R10: Once set, `force_train` stays 1 until an edge samples `if_en`=0. It then clears at the first later edge that samples `if_en`=1. Clearing status bits does not release it.
- R11: A write with `csr_sel`=3 clears each status bit whose `csr_wdata` bit (8:0) is 1, and leaves every other bit unchanged. If an event sets a bit in the same cycle as a write clears it, the set wins.
- R12: While `if_en`=0, frames are ignored and both runs are reset to zero. Other `csr_sel` codes are: 0 = limits (DIP2 in `csr_wdata[3:0]`, framing in `csr_wdata[7:4]`), 1 = interrupt mask [7:0], 2 = fatal mask [7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| if_en | input | 1 | Interface enable |
| frm_valid | input | 1 | One decoded status frame this cycle |
| frm_dip_bad | input | 1 | DIP2 check of the frame failed |
| frm_unexp | input | 1 | Framing code seen where not expected |
| ext_evt | input | 4 | Error pulses from neighbouring logic |
| csr_wr | input | 1 | Configuration write strobe |
| csr_sel | input | 2 | Write target select |
| csr_wdata | input | 16 | Write data |
| irq | output | 1 | Interrupt request |
| sync_err | output | 1 | Fatal event has occurred (sticky) |
| force_train | output | 1 | Hold transmit datapath in training |
| int_status | output | 9 | Sticky status bits |

## Verification
The bench aims at the run boundaries. A run exactly at the limit must not trip; a design that compares with greater-or-equal would declare no-sync one frame early. A good frame inside a run must restart it; a design that forgets this would trip on scattered errors. Further checks cover a run left over from before the interface was disabled, clear-versus-set in the same cycle, a write of zeros that must clear nothing, and a forced-training request that must survive status clears and release only after the full low-then-high enable toggle.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
  localparam int NSRC  = 8;
  localparam int NEXT  = 4;
  localparam int LIM_W = 4;
  localparam int CSR_W = 16;

  localparam int B_DIP    = 4;
  localparam int B_NOSYNC = 5;
  localparam int B_UNX    = 6;
  localparam int B_FRMERR = 7;

  typedef enum logic [1:0] {
    SEL_LIMITS    = 2'd0,
    SEL_IRQ_MASK  = 2'd1,
    SEL_SYNC_MASK = 2'd2,
    SEL_CLEAR     = 2'd3
  } csr_sel_e;
endpackage

// File: rtl/ssm_run_counter.sv
module ssm_run_counter #(
  parameter int LIM_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             hit,
  input  logic             miss,
  input  logic [LIM_W-1:0] limit,
  output logic             trip
);
  localparam logic [LIM_W-1:0] CNT_MAX = {LIM_W{1'b1}};

  logic [LIM_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || clr)       cnt <= '0;
    else if (hit)            cnt <= (cnt == CNT_MAX) ? cnt : cnt + 1'b1;
    else if (miss)           cnt <= '0;
  end

  // Run exceeds limit: this bad frame is number cnt+1 > limit.
  assign trip = hit && (limit != '0) && (cnt >= limit);

  p_run_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (miss && !hit) |=> (cnt == '0));

  p_run_cleared_r12: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));
endmodule

// File: rtl/ssm_irq_regs.sv
module ssm_irq_regs
  import ssm_pkg::*;
#(
  parameter int N     = NSRC,
  parameter int LW    = LIM_W,
  parameter int DW    = CSR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  ev,
  input  logic          csr_wr,
  input  logic [1:0]    csr_sel,
  input  logic [DW-1:0] csr_wdata,
  output logic [LW-1:0] dip_limit,
  output logic [LW-1:0] frm_limit,
  output logic [N:0]    stat,
  output logic          irq,
  output logic          fatal
);
  logic [N-1:0] irq_mask;
  logic [N-1:0] sync_mask;
  logic [N:0]   clr_vec;
  csr_sel_e     sel;

  assign sel     = csr_sel_e'(csr_sel);
  assign fatal   = |(ev & sync_mask);
  assign clr_vec = (csr_wr && sel == SEL_CLEAR) ? csr_wdata[N:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dip_limit <= '0;
      frm_limit <= '0;
      irq_mask  <= '0;
      sync_mask <= '0;
    end else if (csr_wr) begin
      case (sel)
        SEL_LIMITS: begin
          dip_limit <= csr_wdata[LW-1:0];
          frm_limit <= csr_wdata[2*LW-1:LW];
        end
        SEL_IRQ_MASK:  irq_mask  <= csr_wdata[N-1:0];
        SEL_SYNC_MASK: sync_mask <= csr_wdata[N-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stat <= '0;
    else        stat <= (stat & ~clr_vec) | {fatal, ev};
  end

  assign irq = |(stat[N-1:0] & irq_mask);

  p_sticky_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(csr_wr && sel == SEL_CLEAR) |=> ((stat & $past(stat)) == $past(stat)));

  p_sync_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fatal |=> stat[N]);

  p_nosync_needs_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[B_NOSYNC]) |-> ($past(dip_limit) != '0));

  p_frmerr_needs_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[B_FRMERR]) |-> ($past(frm_limit) != '0));
endmodule

// File: rtl/ssm_train_ctl.sv
module ssm_train_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic fatal,
  input  logic if_en,
  output logic force_train
);
  logic seen_low;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      force_train <= 1'b0;
      seen_low    <= 1'b0;
    end else if (fatal) begin
      force_train <= 1'b1;
      seen_low    <= 1'b0;
    end else if (force_train && !if_en) begin
      seen_low    <= 1'b1;
    end else if (force_train && seen_low && if_en) begin
      force_train <= 1'b0;
      seen_low    <= 1'b0;
    end
  end

  p_train_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fatal |=> force_train);

  p_train_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (force_train && !if_en) |=> force_train);

  p_train_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(force_train) |-> $past(if_en));
endmodule

// File: rtl/stat_sync_monitor.sv
module stat_sync_monitor
  import ssm_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            if_en,
  input  logic            frm_valid,
  input  logic            frm_dip_bad,
  input  logic            frm_unexp,
  input  logic [NEXT-1:0] ext_evt,
  input  logic            csr_wr,
  input  logic [1:0]      csr_sel,
  input  logic [CSR_W-1:0] csr_wdata,
  output logic            irq,
  output logic            sync_err,
  output logic            force_train,
  output logic [NSRC:0]   int_status
);
  localparam int NCHK = 2;

  logic             fv;
  logic [NCHK-1:0]  bad;
  logic [NCHK-1:0]  trip;
  logic [LIM_W-1:0] lim [NCHK];
  logic [LIM_W-1:0] dip_limit, frm_limit;
  logic [NSRC-1:0]  ev;
  logic             fatal;

  assign fv      = frm_valid && if_en;
  assign bad[0]  = frm_dip_bad;
  assign bad[1]  = frm_unexp;
  assign lim[0]  = dip_limit;
  assign lim[1]  = frm_limit;

  for (genvar k = 0; k < NCHK; k++) begin : g_run
    ssm_run_counter #(.LIM_W(LIM_W)) i_run (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (!if_en),
      .hit   (fv && bad[k]),
      .miss  (fv && !bad[k]),
      .limit (lim[k]),
      .trip  (trip[k])
    );
  end

  always_comb begin
    ev           = '0;
    ev[NEXT-1:0] = ext_evt;
    ev[B_DIP]    = fv && frm_dip_bad;
    ev[B_NOSYNC] = trip[0];
    ev[B_UNX]    = fv && frm_unexp;
    ev[B_FRMERR] = trip[1];
  end

  ssm_irq_regs i_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev        (ev),
    .csr_wr    (csr_wr),
    .csr_sel   (csr_sel),
    .csr_wdata (csr_wdata),
    .dip_limit (dip_limit),
    .frm_limit (frm_limit),
    .stat      (int_status),
    .irq       (irq),
    .fatal     (fatal)
  );

  ssm_train_ctl i_train (
    .clk         (clk),
    .rst_n       (rst_n),
    .fatal       (fatal),
    .if_en       (if_en),
    .force_train (force_train)
  );

  assign sync_err = int_status[NSRC];

  p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (int_status[NSRC-1:0] != '0));

  p_idle_frames_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!if_en && !(csr_wr && csr_sel == 2'd3) && ext_evt == '0)
      |=> ($stable(int_status[B_FRMERR:B_DIP])));
endmodule

// File: tb/test_stat_sync_monitor.sv
module test_stat_sync_monitor;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        if_en;
  logic        frm_valid, frm_dip_bad, frm_unexp;
  logic [3:0]  ext_evt;
  logic        csr_wr;
  logic [1:0]  csr_sel;
  logic [15:0] csr_wdata;
  logic        irq, sync_err, force_train;
  logic [8:0]  int_status;

  int checks = 0;
  int bad    = 0;
  bit done   = 0;

  typedef struct {
    logic [8:0] stat;
    logic       irq;
    logic       frc;
    string      tag;
  } exp_t;

  exp_t q[$];

  always #5 clk = ~clk;

  stat_sync_monitor i_stat_sync_monitor (
    .clk(clk), .rst_n(rst_n), .if_en(if_en),
    .frm_valid(frm_valid), .frm_dip_bad(frm_dip_bad), .frm_unexp(frm_unexp),
    .ext_evt(ext_evt), .csr_wr(csr_wr), .csr_sel(csr_sel), .csr_wdata(csr_wdata),
    .irq(irq), .sync_err(sync_err), .force_train(force_train), .int_status(int_status)
  );

  // Monitor: compare each queued expectation at the falling edge after its cycle.
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (int_status !== e.stat || irq !== e.irq || sync_err !== e.stat[8] ||
            force_train !== e.frc) begin
          bad++;
          $display("FAIL %s: stat=%h irq=%b sync=%b force=%b expected stat=%h irq=%b sync=%b force=%b",
                   e.tag, int_status, irq, sync_err, force_train,
                   e.stat, e.irq, e.stat[8], e.frc);
        end
      end
    end
  end

  task automatic expect_now(input logic [8:0] s, input logic i, input logic f, input string tag);
    exp_t e;
    e.stat = s; e.irq = i; e.frc = f; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic tick();
    @(posedge clk); #1;
    frm_valid = 0; frm_dip_bad = 0; frm_unexp = 0;
    ext_evt = '0; csr_wr = 0; csr_sel = '0; csr_wdata = '0;
  endtask

  task automatic frame(input logic b, input logic u);
    frm_valid = 1; frm_dip_bad = b; frm_unexp = u;
    tick();
  endtask

  task automatic csr(input logic [1:0] s, input logic [15:0] d);
    csr_wr = 1; csr_sel = s; csr_wdata = d;
    tick();
  endtask

  task automatic ext(input logic [3:0] v);
    ext_evt = v;
    tick();
  endtask

  initial begin
    int n = 0;
    while (!done && n < 100000) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      bad++;
      checks++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; if_en = 1;
    frm_valid = 0; frm_dip_bad = 0; frm_unexp = 0;
    ext_evt = '0; csr_wr = 0; csr_sel = '0; csr_wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick(); expect_now(9'h000, 0, 0, "R1 reset state");

    frame(1, 0);  expect_now(9'h010, 0, 0, "R2 dip error sticky");
    csr(3, 16'h01FF); expect_now(9'h000, 0, 0, "R11 clear all");

    // Limits are zero: long runs never trip.
    frame(1, 1); frame(1, 1); frame(1, 1); frame(1, 1);
    expect_now(9'h050, 0, 0, "R6 zero limit disables both checks");
    frame(0, 0);
    csr(3, 16'h01FF);

    csr(0, 16'h0022);
    frame(1, 0); frame(1, 0); expect_now(9'h010, 0, 0, "R4 run at limit no trip");
    frame(1, 0); expect_now(9'h030, 0, 0, "R4 run past limit sets no-sync");
    frame(0, 0); csr(3, 16'h01FF);
    frame(1, 0); frame(1, 0); frame(0, 0); frame(1, 0); frame(1, 0);
    expect_now(9'h010, 0, 0, "R4 good frame restarts run");
    frame(0, 0); csr(3, 16'h01FF);

    frame(0, 1); expect_now(9'h040, 0, 0, "R3 unexpected framing sticky");
    frame(0, 1); expect_now(9'h040, 0, 0, "R5 run at limit no trip");
    frame(0, 1); expect_now(9'h0C0, 0, 0, "R5 run past limit sets framing error");
    frame(0, 0); csr(3, 16'h01FF);
    frame(0, 1); frame(0, 1); frame(0, 0); frame(0, 1); frame(0, 1);
    expect_now(9'h040, 0, 0, "R5 good frame restarts run");
    frame(0, 0); csr(3, 16'h01FF);

    ext(4'b1010); expect_now(9'h00A, 0, 0, "R7 external events map to bits 3:0");
    csr(3, 16'h01FF);

    csr(1, 16'h0008);
    ext(4'b0001); expect_now(9'h001, 0, 0, "R8 unmasked source no irq");
    ext(4'b1000); expect_now(9'h009, 1, 0, "R8 masked source raises irq");
    csr(3, 16'h0008); expect_now(9'h001, 0, 0, "R8 irq drops after clear");
    csr(1, 16'h0000);

    csr(3, 16'h0000); expect_now(9'h001, 0, 0, "R11 writing zero clears nothing");
    csr(3, 16'h0002); expect_now(9'h001, 0, 0, "R11 other bit untouched");
    csr(3, 16'h0001); expect_now(9'h000, 0, 0, "R11 targeted clear");
    ext_evt = 4'b0001; csr_wr = 1; csr_sel = 2'd3; csr_wdata = 16'h0001;
    tick(); expect_now(9'h001, 0, 0, "R11 set beats clear");
    csr(3, 16'h01FF);

    csr(2, 16'h0020);
    ext(4'b0100); expect_now(9'h004, 0, 0, "R9 non-fatal event no sync");
    csr(3, 16'h01FF);
    frame(0, 0); frame(1, 0); frame(1, 0); frame(1, 0);
    expect_now(9'h130, 0, 1, "R9 fatal no-sync sets sync_err and training");
    tick(); tick(); expect_now(9'h130, 0, 1, "R10 training holds");
    csr(3, 16'h01FF); expect_now(9'h000, 0, 1, "R10 status clear keeps training");

    if_en = 0;
    tick(); expect_now(9'h000, 0, 1, "R10 still training while disabled");
    frame(1, 1); expect_now(9'h000, 0, 1, "R12 frames ignored while disabled");
    if_en = 1;
    tick(); expect_now(9'h000, 0, 0, "R10 released after enable toggle");
    frame(1, 0); frame(1, 0); expect_now(9'h010, 0, 0, "R12 run restarted by disable");

    tick(); tick(); tick();
    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule